// File: doc/BRIEF.md
# Per-Packet Scratch Memory Initializer

This block holds the sixteen 32-bit scratch slots that a packet-filter execution core uses while it judges one packet. When a start-of-packet strobe arrives, the block wipes every slot and then writes a set of per-packet facts into the top five slots: the filter program's size, the size of the whole program-plus-data buffer, a derived IPv4 header length, the packet length, and the age of the installed filter in whole seconds. Once those writes are complete it raises `ready`, and from then on the core reads and writes slots through a small extended-code port.

The IPv4 header length is taken from one byte of the packet, the first byte after the link-layer header. The block fetches it through a byte read port with one cycle of latency. The filter age comes from a free-running seconds counter inside the block. A filter-installed strobe zeroes that counter, a one-second tick advances it, and it sticks at its maximum value rather than wrapping.

Top module: `pkt_scratch_mem`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 0, every slot reads 0 and the age counter is 0.
- R2: A `sop` sampled at clock edge E makes `ready` 0 after E. If `sop` stays low at the next two edges, `ready` becomes 1 after edge E+2. A `sop` at any time restarts this sequence.
- R3: When `ready` rises, slots 0 to 10 read 0, whatever was stored in them for the previous packet.
- R4: When `ready` rises, slot 11 holds `prog_size`, slot 12 holds `buf_size` and slot 14 holds `pkt_len`, each as captured at the `sop` edge and zero-extended.
- R5: The block presents `pkt_rd_addr` = captured `hdr_len` and samples `pkt_rd_data` one cycle later. If bits 7:4 of that byte equal 4, slot 13 holds 4 × bits 3:0.
- R6: Slot 13 holds 0 in either of two cases: bits 7:4 of the fetched byte are not 4, or `hdr_len` ≥ `pkt_len` (the version byte lies outside the packet).
- R7: `filter_load` zeroes the age counter and takes priority over `sec_tick`. Otherwise each `sec_tick` adds one, and the counter saturates at 2^AGE_W−1. Slot 15 holds the age as it stands at the end of preload.
- R8: A code with bits 5:4 = 00 (codes 0–15) returns, on `ext_rdata`, the slot given by bits 3:0, in the same cycle. Any other code returns 0.
- R9: With `ready` high, `ext_valid` together with a code whose bits 5:4 = 01 (codes 16–31) writes `ext_wdata` into slot bits 3:0 at the next edge.
- R10: A store is ignored in two cases: it is presented while `ready` is low, or its code has bits 5:4 other than 01 (for example 32 or 48).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sop | input | 1 | Start-of-packet strobe; captures the metadata inputs |
| prog_size | input | DATA_W | Filter program size in bytes |
| buf_size | input | DATA_W | Total program-plus-data buffer size in bytes |
| pkt_len | input | LEN_W | Packet length in bytes, link-layer header included |
| hdr_len | input | LEN_W | Link-layer header length in bytes |
| pkt_rd_addr | output | LEN_W | Byte address into the packet |
| pkt_rd_data | input | 8 | Packet byte, valid one cycle after its address |
| sec_tick | input | 1 | One-second tick |
| filter_load | input | 1 | Filter-installed strobe |
| ext_valid | input | 1 | Qualifies a store code |
| ext_code | input | 6 | Extended code: 0–15 load slot, 16–31 store slot |
| ext_wdata | input | DATA_W | Store data |
| ext_rdata | output | DATA_W | Load data for the current code |
| ready | output | 1 | Slots cleared and preloaded; core may run |

## Verification
The bench builds the block with AGE_W = 3, so the age counter saturates at 7 after only a handful of ticks. This lets the bench check saturation, and the case where an install strobe and a tick arrive together, within a short run. LEN_W = 8 with a 64-byte packet model keeps the short-packet boundary cases easy to reach: a header length equal to the packet length, and a header length one below it. Packets with a matching version nibble, a mismatched nibble and a truncated packet are interleaved with stores that are legal, early or carry an out-of-range code.

// File: rtl/pkt_scratch_pkg.sv
// Package: shared constants, sequencer state and the header-length helper
// for the per-packet scratch memory. Assumes exactly sixteen slots, because
// the extended code space decodes four slot-index bits.
package pkt_scratch_pkg;

    localparam int unsigned SLOTS      = 16;
    localparam int unsigned SLOT_IDX_W = $clog2(SLOTS);
    localparam int unsigned CODE_W     = 6;

    // Preloaded slot positions (decoded by the filter core, so fixed)
    localparam int unsigned SLOT_PROG = 11;
    localparam int unsigned SLOT_BUF  = 12;
    localparam int unsigned SLOT_IHL  = 13;
    localparam int unsigned SLOT_PLEN = 14;
    localparam int unsigned SLOT_AGE  = 15;

    // Extended code groups in code bits 5:4
    localparam logic [1:0] GRP_LOAD  = 2'b00;
    localparam logic [1:0] GRP_STORE = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD,
        ST_READY
    } seq_state_t;

    // Header length in bytes from the version/length byte; zero when absent or not version 4
    function automatic logic [7:0] ipv4_hdr_bytes(input logic [7:0] vbyte, input logic present);
        if (present && (vbyte[7:4] == 4'd4))
            return {2'b00, vbyte[3:0], 2'b00};
        else
            return 8'd0;
    endfunction

endpackage

// File: rtl/scratch_age_ctr.sv
// Filter-age counter: counts one-second ticks since the last filter install.
// Assumes install and tick are single-cycle strobes; install wins when both
// arrive together. Saturates at all-ones.
module scratch_age_ctr #(
    parameter int AGE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             install,
    input  logic             tick,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    // Clear on reset or install, otherwise advance on tick until saturated
    always_ff @(posedge clk) begin
        if (!rst_n || install)
            age <= '0;
        else if (tick && (age != AGE_MAX))
            age <= age + 1'b1;
    end
endmodule

// File: rtl/scratch_seq.sv
// Start-of-packet sequencer: captures packet metadata, spends one cycle
// clearing the slots (while the version byte is fetched) and one cycle
// preloading, then holds ready until the next start-of-packet.
// Assumes the packet byte port returns data one cycle after the address.
module scratch_seq
    import pkt_scratch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop,
    input  logic [DATA_W-1:0] prog_size,
    input  logic [DATA_W-1:0] buf_size,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [LEN_W-1:0]  hdr_len,
    output logic [LEN_W-1:0]  rd_addr,
    input  logic [7:0]        rd_byte,
    output logic              clr,
    output logic              fill,
    output logic              ready,
    output logic [DATA_W-1:0] prog_q,
    output logic [DATA_W-1:0] buf_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [7:0]        ihl
);
    seq_state_t       state;
    logic [LEN_W-1:0] hdr_q;

    // State progression: any sop restarts, otherwise clear -> load -> ready
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (sop)
            state <= ST_CLEAR;
        else begin
            case (state)
                ST_CLEAR: state <= ST_LOAD;
                ST_LOAD:  state <= ST_READY;
                default:  state <= state;
            endcase
        end
    end

    // Metadata capture at start-of-packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= '0;
            buf_q  <= '0;
            len_q  <= '0;
            hdr_q  <= '0;
        end else if (sop) begin
            prog_q <= prog_size;
            buf_q  <= buf_size;
            len_q  <= pkt_len;
            hdr_q  <= hdr_len;
        end
    end

    // Version byte address and derived header length
    always_comb begin
        rd_addr = hdr_q;
        ihl     = ipv4_hdr_bytes(rd_byte, hdr_q < len_q);
    end

    // Phase strobes decoded from state
    always_comb begin
        clr   = (state == ST_CLEAR);
        fill  = (state == ST_LOAD);
        ready = (state == ST_READY);
    end
endmodule

// File: rtl/scratch_bank.sv
// Slot storage: sixteen registers with a bulk clear, a parallel preload of
// the metadata slots and one store port. Clear beats preload beats store.
// Assumes the preload values are stable during the fill cycle.
module scratch_bank
    import pkt_scratch_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         fill,
    input  logic [DATA_W-1:0]            pre_prog,
    input  logic [DATA_W-1:0]            pre_buf,
    input  logic [DATA_W-1:0]            pre_ihl,
    input  logic [DATA_W-1:0]            pre_len,
    input  logic [DATA_W-1:0]            pre_age,
    input  logic                         st_en,
    input  logic [SLOT_IDX_W-1:0]        st_idx,
    input  logic [DATA_W-1:0]            st_data,
    output logic [SLOTS-1:0][DATA_W-1:0] slots
);
    logic [DATA_W-1:0] mem      [SLOTS];
    logic [DATA_W-1:0] pre_full [SLOTS];
    logic [SLOTS-1:0]  pre_mask;

    // Map the preload values onto their slot positions
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            pre_full[i] = '0;
            pre_mask[i] = 1'b0;
        end
        pre_full[SLOT_PROG] = pre_prog;
        pre_full[SLOT_BUF]  = pre_buf;
        pre_full[SLOT_IHL]  = pre_ihl;
        pre_full[SLOT_PLEN] = pre_len;
        pre_full[SLOT_AGE]  = pre_age;
        pre_mask[SLOT_AGE:SLOT_PROG] = '1;
    end

    // Slot update with clear, preload and store priority
    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (!rst_n || clr)
                mem[i] <= '0;
            else if (fill && pre_mask[i])
                mem[i] <= pre_full[i];
            else if (st_en && (st_idx == SLOT_IDX_W'(i)))
                mem[i] <= st_data;
        end
    end

    // Flatten slots for the read path
    for (genvar g = 0; g < SLOTS; g++) begin : g_out
        assign slots[g] = mem[g];
    end
endmodule

// File: rtl/pkt_scratch_mem.sv
// Top: per-packet scratch memory. Ties the sequencer, age counter and slot
// bank together and decodes the extended load/store codes.
// Assumes AGE_W <= DATA_W and LEN_W <= DATA_W.
module pkt_scratch_mem
    import pkt_scratch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int AGE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop,
    input  logic [DATA_W-1:0] prog_size,
    input  logic [DATA_W-1:0] buf_size,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [LEN_W-1:0]  hdr_len,
    output logic [LEN_W-1:0]  pkt_rd_addr,
    input  logic [7:0]        pkt_rd_data,
    input  logic              sec_tick,
    input  logic              filter_load,
    input  logic              ext_valid,
    input  logic [5:0]        ext_code,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] ext_rdata,
    output logic              ready
);
    logic                         clr, fill;
    logic [DATA_W-1:0]            prog_q, buf_q;
    logic [LEN_W-1:0]             len_q;
    logic [7:0]                   ihl;
    logic [AGE_W-1:0]             age_q;
    logic                         st_en;
    logic [SLOTS-1:0][DATA_W-1:0] slot_vec;

    scratch_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sop(sop),
        .prog_size(prog_size), .buf_size(buf_size),
        .pkt_len(pkt_len), .hdr_len(hdr_len),
        .rd_addr(pkt_rd_addr), .rd_byte(pkt_rd_data),
        .clr(clr), .fill(fill), .ready(ready),
        .prog_q(prog_q), .buf_q(buf_q), .len_q(len_q), .ihl(ihl)
    );

    scratch_age_ctr #(.AGE_W(AGE_W)) u_age (
        .clk(clk), .rst_n(rst_n), .install(filter_load),
        .tick(sec_tick), .age(age_q)
    );

    // Stores only land in the store group and only while ready
    always_comb st_en = ext_valid && ready && (ext_code[5:4] == GRP_STORE);

    scratch_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fill(fill),
        .pre_prog(prog_q), .pre_buf(buf_q),
        .pre_ihl(DATA_W'(ihl)), .pre_len(DATA_W'(len_q)),
        .pre_age(DATA_W'(age_q)),
        .st_en(st_en), .st_idx(ext_code[SLOT_IDX_W-1:0]),
        .st_data(ext_wdata), .slots(slot_vec)
    );

    // Load group returns the addressed slot, other groups return zero
    always_comb begin
        if (ext_code[5:4] == GRP_LOAD)
            ext_rdata = slot_vec[ext_code[SLOT_IDX_W-1:0]];
        else
            ext_rdata = '0;
    end
endmodule

// File: rtl/pkt_scratch_chk.sv
// Checker: temporal properties of the scratch memory, bound to the top.
module pkt_scratch_chk
    import pkt_scratch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AGE_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sop,
    input logic                         ready,
    input logic                         ext_valid,
    input logic [5:0]                   ext_code,
    input logic [DATA_W-1:0]            ext_wdata,
    input logic [DATA_W-1:0]            ext_rdata,
    input logic                         sec_tick,
    input logic                         filter_load,
    input logic [AGE_W-1:0]             age,
    input logic [SLOTS-1:0][DATA_W-1:0] slots
);
    logic low_zero;

    // Whether every non-preloaded slot is zero
    always_comb begin
        low_zero = 1'b1;
        for (int i = 0; i < SLOT_PROG; i++)
            if (slots[i] != '0) low_zero = 1'b0;
    end

    p_sop_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sop |=> !ready);

    p_ready_after_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sop, 2) && !$past(sop) && !sop) |=> ready);

    p_clear_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> low_zero);

    p_ihl_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ((slots[SLOT_IHL][1:0] == 2'b00) && (slots[SLOT_IHL] <= DATA_W'(60))));

    p_age_install_r7: assert property (@(posedge clk) disable iff (!rst_n)
        filter_load |=> (age == '0));

    p_age_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !filter_load && (age != '1)) |=> (age == AGE_W'($past(age) + 1'b1)));

    p_age_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !filter_load && (age == '1)) |=> (age == '1));

    p_age_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !filter_load) |=> $stable(age));

    p_load_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_code[5:4] == GRP_LOAD) |-> (ext_rdata == slots[ext_code[3:0]]));

    p_other_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_code[5:4] != GRP_LOAD) |-> (ext_rdata == '0));

    p_store_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !sop && ext_valid && (ext_code[5:4] == GRP_STORE))
        |=> (slots[$past(ext_code[3:0])] == $past(ext_wdata)));
endmodule

bind pkt_scratch_mem pkt_scratch_chk #(.DATA_W(DATA_W), .AGE_W(AGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sop(sop), .ready(ready),
    .ext_valid(ext_valid), .ext_code(ext_code), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .sec_tick(sec_tick), .filter_load(filter_load),
    .age(age_q), .slots(slot_vec)
);

// File: tb/tb_pkt_scratch_mem.sv
module tb_pkt_scratch_mem;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;
    localparam int AGE_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sop = 1'b0;
    logic [DATA_W-1:0] prog_size = '0;
    logic [DATA_W-1:0] buf_size = '0;
    logic [LEN_W-1:0]  pkt_len = '0;
    logic [LEN_W-1:0]  hdr_len = '0;
    logic [LEN_W-1:0]  pkt_rd_addr;
    logic [7:0]        pkt_rd_data = '0;
    logic              sec_tick = 1'b0;
    logic              filter_load = 1'b0;
    logic              ext_valid = 1'b0;
    logic [5:0]        ext_code = '0;
    logic [DATA_W-1:0] ext_wdata = '0;
    logic [DATA_W-1:0] ext_rdata;
    logic              ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]        pkt_mem [64];
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    pkt_scratch_mem #(.DATA_W(DATA_W), .LEN_W(LEN_W), .AGE_W(AGE_W)) dut (.*);

    always #10 clk = ~clk;

    // Packet byte memory with one cycle of read latency
    always @(posedge clk) pkt_rd_data <= pkt_mem[pkt_rd_addr[5:0]];

    task automatic check(input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Driver: present a load code and queue the expected read value
    task automatic rd(input logic [5:0] code, input logic [DATA_W-1:0] exp, input string tag);
        @(posedge clk); #1;
        ext_valid = 1'b0;
        ext_code  = code;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the read port against the scoreboard mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(ext_rdata, e, t);
        end
    end

    task automatic wr(input logic [5:0] code, input logic [DATA_W-1:0] data);
        @(posedge clk); #1;
        ext_valid = 1'b1; ext_code = code; ext_wdata = data;
        @(posedge clk); #1;
        ext_valid = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1; sec_tick = 1'b1;
            @(posedge clk); #1; sec_tick = 1'b0;
        end
    endtask

    task automatic run_pkt(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] b,
                           input logic [LEN_W-1:0] len, input logic [LEN_W-1:0] hdr);
        @(posedge clk); #1;
        sop = 1'b1; prog_size = p; buf_size = b; pkt_len = len; hdr_len = hdr;
        @(posedge clk); #1;
        sop = 1'b0;
        check(ready, 0, "R2 clear phase");
        @(posedge clk); #1;
        check(ready, 0, "R2 preload phase");
        @(posedge clk); #1;
        check(ready, 1, "R2 ready after two cycles");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog got=running exp=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) pkt_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check(ready, 0, "R1 ready low");
        rd(6'd0, 0, "R1 slot0");
        rd(6'd11, 0, "R1 slot11");
        rd(6'd15, 0, "R1 slot15 age");

        // Packet A: IPv4 byte 0x45 after a 14-byte header, age 3
        @(posedge clk); #1 filter_load = 1'b1;
        @(posedge clk); #1 filter_load = 1'b0;
        pulse_tick(3);
        pkt_mem[14] = 8'h45;
        run_pkt(32'd100, 32'd2048, 8'd60, 8'd14);
        rd(6'd11, 100, "R4 program size");
        rd(6'd12, 2048, "R4 buffer size");
        rd(6'd14, 60, "R4 packet length");
        rd(6'd13, 20, "R5 ihl 0x45");
        rd(6'd15, 3, "R7 age three");

        // R9: legal store then read back
        wr(6'd19, 32'hDEADBEEF);
        rd(6'd3, 32'hDEADBEEF, "R9 store slot3");
        // R10: codes outside the store group write nothing
        wr(6'd32, 32'h11111111);
        wr(6'd48, 32'h22222222);
        rd(6'd0, 0, "R10 code32/48 no write slot0");
        rd(6'd3, 32'hDEADBEEF, "R10 slot3 intact");
        // R8: non-load code reads zero
        rd(6'd35, 0, "R8 code35 reads zero");
        rd(6'd19, 0, "R8 store code reads zero");

        // Packet B: version nibble 6, header length 0
        pkt_mem[0] = 8'h65;
        run_pkt(32'd7, 32'd9, 8'd40, 8'd0);
        rd(6'd3, 0, "R3 slot3 cleared");
        rd(6'd13, 0, "R6 non-ipv4 ihl zero");
        rd(6'd14, 40, "R4 packet length B");

        // Packet C: header length equals packet length -> truncated
        pkt_mem[14] = 8'h46;
        run_pkt(32'd1, 32'd2, 8'd14, 8'd14);
        rd(6'd13, 0, "R6 short packet ihl zero");
        // One byte longer: the version byte is present
        run_pkt(32'd1, 32'd2, 8'd15, 8'd14);
        rd(6'd13, 24, "R5 ihl 0x46 boundary");

        // R10: store during the preload cycle is ignored
        @(posedge clk); #1 sop = 1'b1;
        @(posedge clk); #1 sop = 1'b0;
        @(posedge clk); #1 ext_valid = 1'b1; ext_code = 6'd21; ext_wdata = 32'hCAFE0005;
        @(posedge clk); #1 ext_valid = 1'b0;
        check(ready, 1, "R2 ready after busy store");
        rd(6'd5, 0, "R10 busy store ignored");

        // R7: saturation at 7 with a 3-bit counter
        pulse_tick(10);
        run_pkt(32'd1, 32'd2, 8'd15, 8'd14);
        rd(6'd15, 7, "R7 age saturated");

        // R7: install beats a simultaneous tick, then two ticks
        @(posedge clk); #1 filter_load = 1'b1; sec_tick = 1'b1;
        @(posedge clk); #1 filter_load = 1'b0; sec_tick = 1'b0;
        pulse_tick(2);
        run_pkt(32'd1, 32'd2, 8'd15, 8'd14);
        rd(6'd15, 2, "R7 install priority then two ticks");

        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule